// File: doc/BRIEF.md
# DMA Request Issue and Completion Tracker

This block sits between a device's DMA control logic and a memory request port. Each accepted transfer command names a direction (read or write), a start address, a length in bytes and a completion delay in cycles. The block holds the transfer in a small transaction table. It cuts the transfer into packets that never cross a line boundary. It offers those packets to memory one at a time, in the order the commands were accepted.

Memory accepts a packet with a valid/ready handshake. If memory refuses an offered packet, the block stops offering anything. It waits for a one-cycle retry strobe and then offers the same packet again. Every packet carries the index of its table entry as a tag. Memory returns that tag with each response, together with the byte count. The block adds the byte count to the entry's acknowledged total. When the acknowledged total reaches the transfer length, the entry waits out its completion delay. It then pulses a done strobe that carries the tag, and the entry is freed.

A pending flag shows that packets are in flight. A drained flag shows that nothing is in flight and the table is empty.

Top module: `dma_req_tracker`

## Requirements
- R1: Each packet's size equals the smaller of the bytes still to be sent and the bytes left before the next LINE_BYTES-aligned address (64 by default). A transfer's packets cover consecutive addresses, and every packet size is at least 1. Command lengths are at least 1.
- R2: Packets leave in the order in which their commands were accepted. Every packet of one transfer leaves before any packet of a later transfer.
- R3: A packet offered with `req_valid` high and `req_ready` low counts as refused. From the next cycle, `req_valid` stays low until a cycle in which `req_retry` is high. In the cycle after that, the packet is offered again.
- R4: A refused packet is offered again with the same address, size, tag and direction.
- R5: `req_tag` is the index of the table entry that holds the packet's transfer, from 0 to SLOTS-1. All packets of a transfer carry the same tag. A new command takes the lowest-numbered free entry, so the first command after reset gets tag 0.
- R6: A response adds `rsp_size` to the acknowledged byte count of entry `rsp_tag`. Take t as the cycle whose closing clock edge receives the response that makes the count equal the length. For completion delay d, `done_valid` is high with `done_tag` equal to the transfer's tag in cycle t+1+d. With d = 0 this is the cycle after the final response.
- R7: Each transfer produces exactly one `done_valid` cycle. If several entries are ready to signal completion in the same cycle, the lowest tag goes first. Each of the others goes in a later cycle, one entry per cycle.
- R8: `cmd_ready` is low while all SLOTS entries (4 by default) are occupied. An entry becomes free at the clock edge that ends its `done_valid` cycle.
- R9: `pending` is high exactly when at least one accepted packet has not yet had its response.
- R10: `drained` is high exactly when no packet is in flight and every table entry is free. This is also the state after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Transfer command offered |
| cmd_ready | output | 1 | A table entry is free; the command is taken when valid and ready are both high |
| cmd_write | input | 1 | 1 = write transfer, 0 = read transfer |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Transfer length in bytes, at least 1 |
| cmd_delay | input | DLY_W | Extra cycles before the done strobe |
| req_valid | output | 1 | Packet offered to memory |
| req_ready | input | 1 | Memory accepts the offered packet |
| req_retry | input | 1 | Memory asks for a refused packet to be offered again |
| req_write | output | 1 | Packet direction |
| req_addr | output | ADDR_W | Packet start address |
| req_size | output | SZ_W | Packet size in bytes |
| req_tag | output | TAG_W | Table entry of the packet's transfer |
| rsp_valid | input | 1 | Response present |
| rsp_tag | input | TAG_W | Tag of the responding packet |
| rsp_size | input | SZ_W | Bytes acknowledged by the response |
| done_valid | output | 1 | One-cycle transfer completion strobe |
| done_tag | output | TAG_W | Tag of the completed transfer |
| pending | output | 1 | Packets in flight |
| drained | output | 1 | Nothing in flight and table empty |

## Verification
The assertions check these properties on every cycle:
- No offered packet crosses a line boundary.
- After a refusal, the port goes quiet and the refused packet's fields stay frozen.
- No entry signals completion twice in a row.
- An accepted packet always leaves `pending` high.
- `drained` never appears together with `pending` or with a full table.

Only the bench's scenarios can show the following:
- The exact split sizes, and that packets keep the order in which their commands were accepted.
- That tags are reused consistently.
- That each done strobe lands on its delayed cycle.
- That entries completing in the same cycle are serialized with the lowest tag first.
- That back-pressure appears when the table is full.

// File: rtl/dma_trk_pkg.sv
package dma_trk_pkg;

    // Life cycle of one transaction table entry; FREE must encode as zero
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_ISSUE = 2'd1,
        SLOT_ACK   = 2'd2,
        SLOT_DELAY = 2'd3
    } slot_st_e;

endpackage

// File: rtl/dma_lowest_pick.sv
module dma_lowest_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/dma_pkt_split.sv
module dma_pkt_split #(
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 64,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int SZ_W  = OFF_W + 1
) (
    input  logic [OFF_W-1:0] off,
    input  logic [LEN_W-1:0] rem,
    output logic [SZ_W-1:0]  size
);

    logic [SZ_W-1:0] room;

    // bytes left before the next line boundary
    assign room = SZ_W'(LINE_BYTES) - {1'b0, off};

    always_comb begin
        if (rem < LEN_W'(room)) size = rem[SZ_W-1:0];
        else                    size = room;
    end

endmodule

// File: rtl/dma_tag_fifo.sv
module dma_tag_fifo #(
    parameter int W     = 2,
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_tag,
    input  logic         pop,
    output logic [W-1:0] head_tag,
    output logic         empty
);

    logic [W-1:0] mem [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [PW:0]   cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign head_tag = mem[rd_q];
    assign empty    = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            cnt_q <= cnt_q + (PW+1)'(push) - (PW+1)'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= push_tag;
    end

endmodule

// File: rtl/dma_req_tracker.sv
module dma_req_tracker
    import dma_trk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int DLY_W      = 8,
    parameter int LINE_BYTES = 64,
    parameter int SLOTS      = 4,
    parameter int OUT_W      = 8,
    localparam int TAG_W = $clog2(SLOTS),
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int SZ_W  = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [DLY_W-1:0]  cmd_delay,
    output logic              req_valid,
    input  logic              req_ready,
    input  logic              req_retry,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [SZ_W-1:0]   req_size,
    output logic [TAG_W-1:0]  req_tag,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [SZ_W-1:0]   rsp_size,
    output logic              done_valid,
    output logic [TAG_W-1:0]  done_tag,
    output logic              pending,
    output logic              drained
);

    typedef struct packed {
        slot_st_e          st;
        logic              wr;
        logic [ADDR_W-1:0] addr;   // next address to issue
        logic [LEN_W-1:0]  rem;    // bytes not yet issued
        logic [LEN_W-1:0]  total;
        logic [LEN_W-1:0]  acked;
        logic [DLY_W-1:0]  cnt;    // delay, counted down once acked
    } slot_t;

    typedef struct packed {
        slot_t [SLOTS-1:0] slot;
        logic              wait_retry;
        logic [OUT_W-1:0]  outst;
    } state_t;

    state_t st_d, st_q;

    logic [SLOTS-1:0] free_vec, fire_vec;
    logic             free_found, fire_found;
    logic [TAG_W-1:0] free_idx, fire_idx;
    logic [TAG_W-1:0] head_tag;
    logic             q_empty;
    logic [SZ_W-1:0]  pkt_size;
    logic             pkt_last, issue_fire, cmd_take;
    logic [LEN_W-1:0] ack_sum;

    for (genvar g = 0; g < SLOTS; g++) begin : g_vec
        assign free_vec[g] = (st_q.slot[g].st == SLOT_FREE);
        assign fire_vec[g] = (st_q.slot[g].st == SLOT_DELAY) && (st_q.slot[g].cnt == '0);
    end

    dma_lowest_pick #(.N(SLOTS)) u_free_pick (
        .req(free_vec), .found(free_found), .idx(free_idx)
    );

    dma_lowest_pick #(.N(SLOTS)) u_fire_pick (
        .req(fire_vec), .found(fire_found), .idx(fire_idx)
    );

    dma_tag_fifo #(.W(TAG_W), .DEPTH(SLOTS)) u_order (
        .clk(clk), .rst_n(rst_n),
        .push(cmd_take), .push_tag(free_idx),
        .pop(issue_fire && pkt_last),
        .head_tag(head_tag), .empty(q_empty)
    );

    dma_pkt_split #(.LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)) u_split (
        .off(st_q.slot[head_tag].addr[OFF_W-1:0]),
        .rem(st_q.slot[head_tag].rem),
        .size(pkt_size)
    );

    assign cmd_ready  = free_found;
    assign cmd_take   = cmd_valid && free_found;
    assign req_valid  = !q_empty && !st_q.wait_retry;
    assign req_write  = st_q.slot[head_tag].wr;
    assign req_addr   = st_q.slot[head_tag].addr;
    assign req_size   = pkt_size;
    assign req_tag    = head_tag;
    assign issue_fire = req_valid && req_ready;
    assign pkt_last   = (LEN_W'(pkt_size) == st_q.slot[head_tag].rem);
    assign ack_sum    = st_q.slot[rsp_tag].acked + LEN_W'(rsp_size);
    assign done_valid = fire_found;
    assign done_tag   = fire_idx;
    assign pending    = (st_q.outst != '0);
    assign drained    = (st_q.outst == '0) && (&free_vec);

    always_comb begin
        st_d = st_q;

        for (int i = 0; i < SLOTS; i++) begin
            if (st_q.slot[i].st == SLOT_DELAY && st_q.slot[i].cnt != '0)
                st_d.slot[i].cnt = st_q.slot[i].cnt - DLY_W'(1);
        end

        if (issue_fire) begin
            st_d.slot[head_tag].addr = st_q.slot[head_tag].addr + ADDR_W'(pkt_size);
            st_d.slot[head_tag].rem  = st_q.slot[head_tag].rem - LEN_W'(pkt_size);
            if (pkt_last) st_d.slot[head_tag].st = SLOT_ACK;
        end

        if (rsp_valid) begin
            st_d.slot[rsp_tag].acked = ack_sum;
            if (ack_sum == st_q.slot[rsp_tag].total)
                st_d.slot[rsp_tag].st = SLOT_DELAY;
        end

        if (fire_found) st_d.slot[fire_idx].st = SLOT_FREE;

        if (cmd_take) begin
            st_d.slot[free_idx].st    = SLOT_ISSUE;
            st_d.slot[free_idx].wr    = cmd_write;
            st_d.slot[free_idx].addr  = cmd_addr;
            st_d.slot[free_idx].rem   = cmd_len;
            st_d.slot[free_idx].total = cmd_len;
            st_d.slot[free_idx].acked = '0;
            st_d.slot[free_idx].cnt   = cmd_delay;
        end

        if (req_valid && !req_ready) st_d.wait_retry = 1'b1;
        else if (req_retry)          st_d.wait_retry = 1'b0;

        st_d.outst = st_q.outst + OUT_W'(issue_fire) - OUT_W'(rsp_valid);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/dma_req_tracker_chk.sv
module dma_req_tracker_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int TAG_W      = 2,
    parameter int SZ_W       = 7,
    localparam int OFF_W = $clog2(LINE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [SZ_W-1:0]   req_size,
    input logic [TAG_W-1:0]  req_tag,
    input logic              done_valid,
    input logic [TAG_W-1:0]  done_tag,
    input logic              pending,
    input logic              drained
);

    // R1: an offered packet is non-empty and stays inside one line
    p_in_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_size != '0) &&
                      ((int'(req_addr[OFF_W-1:0]) + int'(req_size)) <= LINE_BYTES));

    // R3: a refusal silences the port in the following cycle
    p_quiet_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> !req_valid);

    // R4: the refused packet's fields are frozen
    p_hold_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            ($stable(req_addr) && $stable(req_size) && $stable(req_tag)));

    // R7: no entry signals completion in two consecutive cycles
    p_done_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !(done_valid && done_tag == $past(done_tag)));

    // R9: an accepted packet leaves work in flight
    p_pending_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> pending);

    // R10: drained excludes in-flight packets and a full table
    p_drain_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> (!pending && cmd_ready));

endmodule

bind dma_req_tracker dma_req_tracker_chk #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .TAG_W(TAG_W), .SZ_W(SZ_W)
) u_chk (.*);

// File: tb/tb_dma_req_tracker.sv
module tb_dma_req_tracker;

    localparam int PERIOD = 10;
    localparam int LAT    = 3;
    localparam int AW = 32, LW = 16, DW = 8, LINE = 64, SL = 4;
    localparam int TW = 2, SW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic [DW-1:0] cmd_delay = '0;
    logic cmd_ready;
    logic req_valid, req_write;
    logic req_ready = 1'b1, req_retry = 1'b0;
    logic [AW-1:0] req_addr;
    logic [SW-1:0] req_size;
    logic [TW-1:0] req_tag;
    logic rsp_valid = 1'b0;
    logic [TW-1:0] rsp_tag = '0;
    logic [SW-1:0] rsp_size = '0;
    logic done_valid, pending, drained;
    logic [TW-1:0] done_tag;

    dma_req_tracker #(.ADDR_W(AW), .LEN_W(LW), .DLY_W(DW), .LINE_BYTES(LINE), .SLOTS(SL)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_delay(cmd_delay),
        .req_valid(req_valid), .req_ready(req_ready), .req_retry(req_retry),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_size(rsp_size),
        .done_valid(done_valid), .done_tag(done_tag),
        .pending(pending), .drained(drained)
    );

    always #(PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard state
    int x_len[64], x_dly[64], x_tag[64], x_exp[64], x_done[64];
    int nx = 0;
    longint e_addr[$];
    int e_size[$], e_wr[$], e_xid[$];
    int r_tag[$], r_size[$], r_due[$];
    int t_xid[SL], t_ack[SL];
    bit refuse_mode = 0, rsp_pause = 0, waiting = 0;
    int offers = 0, refusals = 0, wait_cnt = 0, done_cnt = 0, prev_done_cyc = -10;
    longint ref_addr = 0;

    // driver: predict the packets, then hand the command over
    task automatic send_cmd(input bit wr, input longint addr, input int len, input int dly);
        int xid;
        longint a;
        int rem;
        xid = nx;
        nx++;
        x_len[xid] = len; x_dly[xid] = dly; x_tag[xid] = -1;
        x_exp[xid] = -1;  x_done[xid] = -1;
        a = addr; rem = len;
        while (rem > 0) begin
            int room;
            int sz;
            room = LINE - int'(a % LINE);
            sz = (rem < room) ? rem : room;
            e_addr.push_back(a); e_size.push_back(sz);
            e_wr.push_back(int'(wr)); e_xid.push_back(xid);
            a += sz; rem -= sz;
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = AW'(addr);
        cmd_len = LW'(len); cmd_delay = DW'(dly);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // monitor and memory model
    int m_xid, m_tg, m_sz;
    bit m_ok;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_valid) begin
                m_xid = t_xid[done_tag];
                m_ok = (cyc == x_exp[m_xid]) ||
                       (cyc == x_exp[m_xid] + 1 && prev_done_cyc == cyc - 1);
                chk(m_ok && x_done[m_xid] < 0, "R6 done cycle", cyc, x_exp[m_xid]);
                x_done[m_xid] = cyc;
                done_cnt++;
                prev_done_cyc = cyc;
            end

            req_retry = 1'b0;
            if (waiting) begin
                if (wait_cnt > 0) begin
                    chk(!req_valid, "R3 quiet while refused", req_valid, 0);
                    wait_cnt--;
                    if (wait_cnt == 0) req_retry = 1'b1;
                    req_ready = 1'b0;
                end else begin
                    waiting = 0;
                    chk(req_valid && req_addr == AW'(ref_addr), "R4 re-offer after retry",
                        req_addr, ref_addr);
                end
            end
            if (!waiting) begin
                req_ready = 1'b1;
                if (req_valid) begin
                    offers++;
                    if (refuse_mode && offers % 3 == 0) begin
                        req_ready = 1'b0;
                        waiting = 1; wait_cnt = 2; ref_addr = req_addr; refusals++;
                    end else if (e_addr.size() == 0) begin
                        chk(0, "R2 unexpected packet", req_addr, 0);
                    end else begin
                        chk(req_addr == AW'(e_addr[0]), "R2 packet address/order", req_addr, e_addr[0]);
                        chk(int'(req_size) == e_size[0], "R1 packet size", req_size, e_size[0]);
                        chk(int'(req_write) == e_wr[0], "R2 packet direction", req_write, e_wr[0]);
                        m_xid = e_xid[0];
                        void'(e_addr.pop_front()); void'(e_size.pop_front());
                        void'(e_wr.pop_front()); void'(e_xid.pop_front());
                        if (x_tag[m_xid] < 0) begin
                            x_tag[m_xid] = int'(req_tag);
                            t_xid[req_tag] = m_xid;
                            t_ack[req_tag] = 0;
                        end else begin
                            chk(int'(req_tag) == x_tag[m_xid], "R5 tag constant", req_tag, x_tag[m_xid]);
                        end
                        r_tag.push_back(int'(req_tag));
                        r_size.push_back(int'(req_size));
                        r_due.push_back(cyc + LAT);
                    end
                end
            end

            if (!rsp_pause && r_tag.size() > 0 && cyc >= r_due[0]) begin
                m_tg = r_tag.pop_front(); m_sz = r_size.pop_front(); void'(r_due.pop_front());
                rsp_valid = 1'b1; rsp_tag = TW'(m_tg); rsp_size = SW'(m_sz);
                t_ack[m_tg] += m_sz;
                m_xid = t_xid[m_tg];
                if (t_ack[m_tg] == x_len[m_xid]) x_exp[m_xid] = cyc + 1 + x_dly[m_xid];
            end else begin
                rsp_valid = 1'b0;
            end
        end
    end

    task automatic wait_idle();
        do @(negedge clk);
        while (!(done_cnt == nx && r_tag.size() == 0 && e_addr.size() == 0));
        @(negedge clk);
        chk(drained && !pending, "R10 drained once idle", drained, 1);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int xa;
        repeat (3) @(negedge clk);
        chk(drained, "R10 reset drained", drained, 1);
        chk(!pending, "R9 reset pending", pending, 0);
        chk(cmd_ready, "R8 reset cmd_ready", cmd_ready, 1);
        chk(!req_valid && !done_valid, "R3 reset quiet", req_valid, 0);
        rst_n = 1'b1;

        // line-crossing splits with various delays
        send_cmd(1, 64'h1000_0030, 100, 0);
        send_cmd(0, 64'h2000, 128, 5);
        send_cmd(1, 64'h303F, 4, 1);
        wait_idle();
        chk(x_tag[0] == 0, "R5 first tag", x_tag[0], 0);

        // refusals and retries
        refuse_mode = 1;
        send_cmd(0, 64'h4010, 200, 2);
        send_cmd(1, 64'h5000, 64, 0);
        wait_idle();
        refuse_mode = 0;
        chk(refusals > 0, "R3 refusals exercised", refusals, 1);

        // full table
        rsp_pause = 1;
        for (int i = 0; i < SL; i++) send_cmd(0, 64'h6000 + 64'(i * 256), 8, 1);
        repeat (4) @(negedge clk);
        chk(!cmd_ready, "R8 full table back-pressure", cmd_ready, 0);
        chk(pending, "R9 pending with responses held", pending, 1);
        chk(!drained, "R10 not drained while busy", drained, 0);
        rsp_pause = 0;
        send_cmd(1, 64'h7000, 8, 0);
        wait_idle();

        // simultaneous completion
        xa = nx;
        send_cmd(0, 64'h100, 8, 4);
        send_cmd(0, 64'h200, 8, 2);
        wait_idle();
        chk(x_tag[xa] == 0 && x_tag[xa+1] == 1, "R5 lowest free entry", x_tag[xa+1], 1);
        chk(x_exp[xa] == x_exp[xa+1], "R7 collision set up", x_exp[xa+1], x_exp[xa]);
        chk(x_done[xa+1] == x_done[xa] + 1, "R7 lowest tag first", x_done[xa+1], x_done[xa] + 1);

        chk(done_cnt == nx, "R7 one done per transfer", done_cnt, nx);
        chk(!pending, "R9 final pending", pending, 0);
        finish_run();
    end

endmodule